// File: doc/BRIEF.md
# Eight-Cell Addressable Latch with Demultiplex Mode

This block holds eight single-bit storage cells. A 3-bit select picks one cell, a single data line supplies the value, and two active-low controls choose what the block does. The enable controls whether the selected cell is written. The clear control empties the array and switches the outputs between the stored contents and a decoder view. Eight parallel outputs give either the stored contents or a demultiplexed copy of the data line, depending on the mode.

The four modes come from the two controls. With clear high and enable low, the selected cell is transparent to the data line. With both high, everything holds. With clear low and enable low, the block works as a 1-of-8 demultiplexer with active-high outputs and does not show its contents. With clear low and enable high, every output is low.

Typical uses are a bank of individually settable control bits, a serial-to-parallel holding register, or an active-high line decoder. Storage is level-sensitive. There is no clock, and every result follows its inputs with no register delay.

Top module: `addr_latch8`

## Requirements
- R1: With clr_n = 1 and en_n = 0 (write mode), output q[n] equals din, where n is the unsigned binary value on sel (sel = 0 selects q[0], sel = 7 selects q[7]).
- R2: In write mode, every cell other than the selected one keeps its previous value, and so does its output.
- R3: With clr_n = 1 and en_n = 1 (hold mode), all eight outputs keep their values whatever din and sel do.
- R4: With clr_n = 0 and en_n = 0 (decode mode), q[sel] equals din and the other seven outputs are 0, so q is either all zero or one-hot.
- R5: With clr_n = 0 and en_n = 1 (clear mode), all eight outputs are 0 whatever din and sel do.
- R6: While clr_n is 0, every stored cell is set to 0. After clr_n returns to 1 with en_n = 1, all outputs read 0, whatever the cells held earlier.
- R7: In write mode the selected cell is transparent: each change of din while the mode lasts shows up on q[sel], and the last value stays stored once en_n rises.
- R8: Decode mode shows only the decoder view: the stored contents never appear on q while clr_n is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_n | input | 1 | Active-low clear; also picks the decoder view while low |
| en_n | input | 1 | Active-low enable for writing or decoding |
| sel | input | 3 | Binary index of the selected cell or output line |
| din | input | 1 | Single-bit data input |
| q | output | 8 | Parallel outputs, bit n belongs to cell n |

## Verification
Every result of this block is due in the same cycle as its stimulus: the cells and the output selection are level-sensitive, so no register stands between an input and q. The bench drives each new input set on the rising clock edge and samples q on the following falling edge, half a period later, when everything has settled. It changes sel only while en_n is high, so it never reads a transient caused by moving the address during a write. The checks on stored state (R2, R3, R6) compare against a bench-side reference array of eight bits, and that array is updated only from the requirements.

// File: rtl/al_pkg.sv
// Package: shared types for the addressable latch.
// Assumes: nothing; only types and a helper function.
package al_pkg;

    // Operating mode decoded from the two active-low controls.
    typedef enum logic [1:0] {
        AL_WRITE  = 2'd0,
        AL_HOLD   = 2'd1,
        AL_DECODE = 2'd2,
        AL_CLEAR  = 2'd3
    } al_mode_e;

    // Map the control pins onto a mode.
    function automatic al_mode_e al_mode_of(input logic clr_n, input logic en_n);
        al_mode_e m;
        case ({clr_n, en_n})
            2'b10:   m = AL_WRITE;
            2'b11:   m = AL_HOLD;
            2'b00:   m = AL_DECODE;
            default: m = AL_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/al_mode_dec.sv
// Module: al_mode_dec
// Turns the clear and enable controls into one of four modes.
// Assumes: both controls are active-low, level-sensitive levels.
module al_mode_dec
    import al_pkg::*;
(
    input  logic     clr_n,
    input  logic     en_n,
    output al_mode_e mode
);

    // Pure mode decode, no state.
    always_comb begin
        mode = al_mode_of(clr_n, en_n);
    end

endmodule

// File: rtl/al_sel_dec.sv
// Module: al_sel_dec
// Binary-to-one-hot decoder for the cell select.
// Assumes: sel values at or above N_CELLS select nothing.
module al_sel_dec #(
    parameter int N_CELLS = 8,
    localparam int SEL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [N_CELLS-1:0] hot
);

    // One compare per output line.
    for (genvar i = 0; i < N_CELLS; i++) begin : g_line
        assign hot[i] = (sel == SEL_W'(i));
    end

endmodule

// File: rtl/al_cell_array.sv
// Module: al_cell_array
// Level-sensitive storage cells, one latch per bit, with a shared clear.
// Assumes: at most one load line is high, and sel is stable while load is high.
module al_cell_array #(
    parameter int N_CELLS = 8
) (
    input  logic               clr_n,
    input  logic [N_CELLS-1:0] load,
    input  logic               din,
    output logic [N_CELLS-1:0] cells
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        // Cell i: clear dominates; otherwise it is transparent while loaded.
        always_latch begin
            if (!clr_n) begin
                cells[i] <= 1'b0;
            end else if (load[i]) begin
                cells[i] <= din;
            end
        end
    end

endmodule

// File: rtl/al_out_mux.sv
// Module: al_out_mux
// Picks the output view for the current mode: the stored contents, the
// decoder view, or all zero.
// Assumes: hot is one-hot or zero.
module al_out_mux
    import al_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  al_mode_e           mode,
    input  logic [N_CELLS-1:0] hot,
    input  logic               din,
    input  logic [N_CELLS-1:0] cells,
    output logic [N_CELLS-1:0] q
);

    // Select the output view from the mode.
    always_comb begin
        case (mode)
            AL_WRITE, AL_HOLD: q = cells;
            AL_DECODE:         q = hot & {N_CELLS{din}};
            default:           q = '0;
        endcase
    end

endmodule

// File: rtl/addr_latch8.sv
// Module: addr_latch8 (top)
// Addressable latch array with four modes chosen by clr_n and en_n:
// write to the selected cell, hold, 1-of-N demultiplex, or clear.
// Assumes: sel changes only while en_n is high. clr_n is the block's
// active-low reset and also empties the storage.
module addr_latch8
    import al_pkg::*;
#(
    parameter int N_CELLS = 8,
    localparam int SEL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clr_n,
    input  logic               en_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic               din,
    output logic [N_CELLS-1:0] q
);

    al_mode_e           mode;
    logic [N_CELLS-1:0] hot;
    logic [N_CELLS-1:0] load;
    logic [N_CELLS-1:0] cells;

    al_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    al_sel_dec #(.N_CELLS(N_CELLS)) u_sel (
        .sel (sel),
        .hot (hot)
    );

    // Gate the one-hot select so that only write mode loads a cell.
    always_comb begin
        load = (mode == AL_WRITE) ? hot : '0;
    end

    al_cell_array #(.N_CELLS(N_CELLS)) u_cells (
        .clr_n (clr_n),
        .load  (load),
        .din   (din),
        .cells (cells)
    );

    al_out_mux #(.N_CELLS(N_CELLS)) u_out (
        .mode  (mode),
        .hot   (hot),
        .din   (din),
        .cells (cells),
        .q     (q)
    );

endmodule

// File: rtl/addr_latch8_chk.sv
// Module: addr_latch8_chk
// Checker for the port-level mode rules of addr_latch8, attached by bind.
// Assumes: the block has no clock, so the checks are immediate and re-run
// on every change of the ports.
module addr_latch8_chk #(
    parameter int N_CELLS = 8,
    localparam int SEL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input logic               clr_n,
    input logic               en_n,
    input logic [SEL_W-1:0]   sel,
    input logic               din,
    input logic [N_CELLS-1:0] q
);

    // Re-check the mode rules whenever a port moves.
    always_comb begin
        if (clr_n && !en_n) begin
            // R1
            wr_follow_chk: assert (q[sel] == din);
        end
        if (!clr_n && !en_n) begin
            // R4
            dec_onehot_chk: assert ($onehot0(q));
            // R8
            dec_view_chk: assert (q == (N_CELLS'(din) << sel));
        end
        if (!clr_n && en_n) begin
            // R5
            clr_zero_chk: assert (q == '0);
        end
    end

endmodule

bind addr_latch8 addr_latch8_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clr_n (clr_n),
    .en_n  (en_n),
    .sel   (sel),
    .din   (din),
    .q     (q)
);

// File: tb/tb_addr_latch8.sv
// Bench for addr_latch8: a vector table, then directed sweeps with a
// reference array. Inputs change on the rising edge, q is sampled on the falling edge.
module tb_addr_latch8;

    logic       clk = 1'b0;
    logic       clr_n, en_n, din;
    logic [2:0] sel;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_q;

    addr_latch8 dut (.clr_n(clr_n), .en_n(en_n), .sel(sel), .din(din), .q(q));

    always #5 clk = ~clk;

    // Vector layout: {clr_n, en_n, sel[2:0], din, expected q[7:0]}
    localparam int NV = 19;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b1, 3'd0, 1'b0, 8'h00},
        {1'b1, 1'b1, 3'd3, 1'b0, 8'h00},
        {1'b1, 1'b0, 3'd3, 1'b1, 8'h08},
        {1'b1, 1'b1, 3'd3, 1'b1, 8'h08},
        {1'b1, 1'b1, 3'd7, 1'b1, 8'h08},
        {1'b1, 1'b0, 3'd7, 1'b1, 8'h88},
        {1'b1, 1'b0, 3'd7, 1'b0, 8'h08},
        {1'b1, 1'b0, 3'd7, 1'b1, 8'h88},
        {1'b1, 1'b1, 3'd7, 1'b1, 8'h88},
        {1'b1, 1'b1, 3'd0, 1'b0, 8'h88},
        {1'b0, 1'b1, 3'd0, 1'b0, 8'h00},
        {1'b0, 1'b1, 3'd5, 1'b1, 8'h00},
        {1'b0, 1'b0, 3'd5, 1'b1, 8'h20},
        {1'b0, 1'b0, 3'd5, 1'b0, 8'h00},
        {1'b0, 1'b1, 3'd5, 1'b0, 8'h00},
        {1'b0, 1'b1, 3'd2, 1'b1, 8'h00},
        {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
        {1'b0, 1'b1, 3'd2, 1'b1, 8'h00},
        {1'b1, 1'b1, 3'd2, 1'b1, 8'h00}
    };

    task automatic drive(input logic c, input logic e, input logic [2:0] s, input logic d);
        @(posedge clk);
        clr_n = c; en_n = e; sel = s; din = d;
        @(negedge clk);
    endtask

    task automatic check(input logic [7:0] exp, input string tag);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%02h expected %02h", tag, q, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hang, expected end)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clr_n = 1'b0; en_n = 1'b1; sel = 3'd0; din = 1'b0;
        repeat (2) @(negedge clk);
        check(8'h00, "R5 reset state");

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
            check(VEC[i][7:0], $sformatf("table %0d (R1 R2 R3 R4 R5 R6 R7)", i));
        end

        // R1 R2 R7: write a pattern through every address.
        ref_q = 8'h00;
        for (int a = 0; a < 8; a++) begin
            logic b;
            b = ((8'hB5 >> a) & 8'h01) != 0;
            drive(1'b1, 1'b1, 3'(a), b);
            drive(1'b1, 1'b0, 3'(a), !b);
            ref_q[a] = !b;
            check(ref_q, "R7 transparent first level");
            drive(1'b1, 1'b0, 3'(a), b);
            ref_q[a] = b;
            check(ref_q, "R1 R2 addressed write");
            drive(1'b1, 1'b1, 3'(a), b);
        end
        check(8'hB5, "R2 pattern stored");

        // R3: hold ignores data and address.
        for (int a = 0; a < 8; a++) begin
            drive(1'b1, 1'b1, 3'(7 - a), a[0]);
            check(8'hB5, "R3 hold ignores inputs");
        end

        // R4 R8: decode sweep with stored contents not shown.
        drive(1'b0, 1'b1, 3'd0, 1'b0);
        for (int a = 0; a < 8; a++) begin
            drive(1'b0, 1'b1, 3'(a), 1'b1);
            drive(1'b0, 1'b0, 3'(a), 1'b1);
            check(8'h01 << a, "R4 decode one line high");
            drive(1'b0, 1'b0, 3'(a), 1'b0);
            check(8'h00, "R8 decode hides contents");
            drive(1'b0, 1'b1, 3'(a), 1'b1);
            check(8'h00, "R5 clear ignores inputs");
        end

        // R6: storage cleared after the clear period.
        drive(1'b1, 1'b1, 3'd4, 1'b1);
        check(8'h00, "R6 cells empty after clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule